// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight level-sensitive interrupt request lines, filters them through an 8-bit mask, and drives one interrupt line to the processor. The interrupt line is driven only when the best pending, unmasked request outranks every level already in service. When the processor acknowledges, the block marks the winning level as in service and returns a memory address for that level's handler slot. The address is formed from a programmable table base and a table spacing of either 4 or 8 bytes.

Software controls the block through a small register port with one address bit. Command writes choose one of four priority schemes: a fixed order, rotation after each end-of-interrupt, an order anchored at a software-chosen lowest level, and a polled scheme in which software reads the highest pending level instead of taking a vectored interrupt. The data address is shared by the mask and by the two bytes of the table base. A setup command decides which of these receives the next writes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are low, every level is masked (a read with `bus_a0`=1 returns 0xFF), the in-service set is empty, the mode is fixed, the spacing is 4 and the base is 0.
- R2: Each clock the request register samples `irq_lines`. A read with `bus_a0`=0 in a non-polled mode, with request readback selected, returns the lines as sampled at the previous edge.
- R3: A write with `bus_a0`=1, when no base load is pending, replaces the mask (bit n set masks level n). It reads back with `bus_a0`=1. A masked level never causes `cpu_int`.
- R4: In fixed mode (command 0x20), level 0 is highest and level 7 lowest, so the lowest-numbered pending level wins.
- R5: `cpu_int` is high only when the winning pending level has strictly higher priority than the highest level in service. A pending level equal to or below it does not raise the line.
- R6: When `cpu_inta` is high in a cycle in which `cpu_int` is high, the winning level enters service at that edge. `vec_valid` is then high for exactly the next cycle, with `vec_addr` set.
- R7: Command 0x00|s selects spacing 4 (s=0) or 8 (s=1). The next two writes with `bus_a0`=1 load the base high byte and then the low byte. `vec_addr` is the base, rounded down to a multiple of 8 times the spacing, plus the level times the spacing.
- R8: Command 0x40 (end of interrupt) removes the highest-priority level from the in-service set. With nothing in service, it has no effect.
- R9: In rotating mode (command 0x21), an end of interrupt makes the level it removed the lowest priority. The level numerically after it becomes the highest.
- R10: In specific mode (command 0x22), command 0x60|L makes level L the lowest, and priority runs L+1, L+2, … modulo 8. An end of interrupt leaves that order unchanged.
- R11: In polled mode (command 0x23), `cpu_int` stays low. A read with `bus_a0`=0 returns bit 7 = any unmasked request pending and bits 2:0 = the highest pending level in fixed order, with other bits 0. That read puts the returned level into service.
- R12: Command 0x80|b selects what a non-polled read with `bus_a0`=0 returns: the request register (b=0) or the in-service register (b=1, bit n = level n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Level-sensitive request lines, bit n = level n |
| bus_a0 | input | 1 | Register address bit: 0 command/status, 1 data |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high, else 0 |
| cpu_int | output | 1 | Interrupt request to the processor |
| cpu_inta | input | 1 | Interrupt acknowledge from the processor |
| vec_valid | output | 1 | One-cycle strobe for `vec_addr` |
| vec_addr | output | 16 | Handler slot address of the acknowledged level |

## Verification
A line change reaches the request register at the next edge. From there, `cpu_int` and the readback follow combinationally in the same cycle, so the bench changes lines at a falling edge and samples one full cycle later. A register write takes effect at the rising edge it spans, and the bench samples at the falling edge after it. A read returns data combinationally while `bus_rd` is high, while its polled side effect lands at the following edge. The handler address comes one edge after the acknowledge. The driver queues each expected address when it pulses `cpu_inta`, and a monitor pops and compares it at the falling edge where `vec_valid` is due. Any strobe that arrives without a queued address is reported.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    PM_FIXED    = 2'd0,
    PM_ROTATE   = 2'd1,
    PM_SPECIFIC = 2'd2,
    PM_POLL     = 2'd3
  } prio_mode_e;

  typedef enum logic [2:0] {
    OP_SETUP  = 3'd0,
    OP_MODE   = 3'd1,
    OP_EOI    = 3'd2,
    OP_LOWEST = 3'd3,
    OP_RDSEL  = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_BASE_HI = 2'd1,
    SQ_BASE_LO = 2'd2
  } load_seq_e;

endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int NLVL = 8
) (
  input  logic [NLVL-1:0]         vec,
  input  logic [$clog2(NLVL)-1:0] lowest,
  output logic                    hit,
  output logic [$clog2(NLVL)-1:0] level
);
  localparam int LVL_W = $clog2(NLVL);

  logic             found;
  logic [LVL_W-1:0] cand;

  // Scan starts just above the lowest level and wraps round.
  always_comb begin
    found = 1'b0;
    level = '0;
    cand  = '0;
    for (int k = 0; k < NLVL; k++) begin
      cand = lowest + LVL_W'(k + 1);
      if (!found && vec[cand]) begin
        found = 1'b1;
        level = cand;
      end
    end
    hit = found;
  end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int NLVL   = 8,
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [$clog2(NLVL)-1:0] level,
  input  logic [ADDR_W-1:0]       base,
  input  logic                    wide,
  output logic                    valid,
  output logic [ADDR_W-1:0]       addr
);
  localparam int LVL_W = $clog2(NLVL);
  localparam int NARROW_SH = 2;
  localparam int WIDE_SH   = 3;

  function automatic logic [ADDR_W-1:0] slot_addr(
    input logic [ADDR_W-1:0] b,
    input logic [LVL_W-1:0]  lv,
    input logic              w
  );
    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] offs;
    span_mask = w ? ADDR_W'((NLVL << WIDE_SH) - 1) : ADDR_W'((NLVL << NARROW_SH) - 1);
    offs      = w ? (ADDR_W'(lv) << WIDE_SH) : (ADDR_W'(lv) << NARROW_SH);
    return (b & ~span_mask) | offs;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else begin
      valid <= fire;
      if (fire) addr <= slot_addr(base, level, wide);
    end
  end

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_prio_pkg::*;
#(
  parameter int NLVL = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_a0,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [NLVL-1:0]         bus_wdata,
  output logic [NLVL-1:0]         bus_rdata,
  input  logic [NLVL-1:0]         irr,
  input  logic [NLVL-1:0]         isr,
  input  logic                    poll_hit,
  input  logic [$clog2(NLVL)-1:0] poll_level,
  input  logic                    serv_hit,
  input  logic [$clog2(NLVL)-1:0] serv_level,
  output logic [NLVL-1:0]         mask,
  output prio_mode_e              mode,
  output logic [$clog2(NLVL)-1:0] lowest,
  output logic [2*NLVL-1:0]       base,
  output logic                    wide,
  output logic                    eoi_pulse,
  output logic                    poll_take
);
  localparam int LVL_W  = $clog2(NLVL);
  localparam int ADDR_W = 2 * NLVL;

  load_seq_e seq;
  logic      rd_isr;
  logic      wr_cmd;
  logic      wr_data;
  cmd_op_e   op;

  assign wr_cmd  = bus_wr && !bus_a0;
  assign wr_data = bus_wr && bus_a0;
  assign op      = cmd_op_e'(bus_wdata[NLVL-1 -: 3]);

  assign eoi_pulse = wr_cmd && (op == OP_EOI);
  assign poll_take = bus_rd && !bus_a0 && (mode == PM_POLL) && poll_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= '1;
      mode   <= PM_FIXED;
      lowest <= '1;
      base   <= '0;
      wide   <= 1'b0;
      seq    <= SQ_IDLE;
      rd_isr <= 1'b0;
    end else begin
      if (wr_cmd) begin
        case (op)
          OP_SETUP: begin
            wide <= bus_wdata[0];
            seq  <= SQ_BASE_HI;
          end
          OP_MODE:   mode   <= prio_mode_e'(bus_wdata[1:0]);
          OP_LOWEST: lowest <= bus_wdata[LVL_W-1:0];
          OP_RDSEL:  rd_isr <= bus_wdata[0];
          OP_EOI: begin
            if (mode == PM_ROTATE && serv_hit) lowest <= serv_level;
          end
          default: ;
        endcase
      end
      if (wr_data) begin
        case (seq)
          SQ_BASE_HI: begin
            base <= {bus_wdata, base[NLVL-1:0]};
            seq  <= SQ_BASE_LO;
          end
          SQ_BASE_LO: begin
            base <= {base[ADDR_W-1:NLVL], bus_wdata};
            seq  <= SQ_IDLE;
          end
          default: mask <= bus_wdata;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_a0)               bus_rdata = mask;
      else if (mode == PM_POLL) bus_rdata = {poll_hit, {(NLVL-1-LVL_W){1'b0}}, poll_level};
      else if (rd_isr)          bus_rdata = isr;
      else                      bus_rdata = irr;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NLVL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   irq_lines,
  input  logic              bus_a0,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NLVL-1:0]   bus_wdata,
  output logic [NLVL-1:0]   bus_rdata,
  output logic              cpu_int,
  input  logic              cpu_inta,
  output logic              vec_valid,
  output logic [2*NLVL-1:0] vec_addr
);
  localparam int LVL_W  = $clog2(NLVL);
  localparam int ADDR_W = 2 * NLVL;

  // Distance below the top of the order; 0 is the highest priority.
  function automatic logic [LVL_W-1:0] prio_rank(
    input logic [LVL_W-1:0] lv,
    input logic [LVL_W-1:0] low
  );
    return lv - low - LVL_W'(1);
  endfunction

  function automatic logic [NLVL-1:0] level_bit(input logic [LVL_W-1:0] lv);
    return NLVL'(1) << lv;
  endfunction

  logic [NLVL-1:0]   irr;
  logic [NLVL-1:0]   isr;
  logic [NLVL-1:0]   mask;
  logic [NLVL-1:0]   pend;
  prio_mode_e        mode;
  logic [LVL_W-1:0]  lowest;
  logic [LVL_W-1:0]  eff_lowest;
  logic [ADDR_W-1:0] base;
  logic              wide;
  logic              eoi_pulse;
  logic              poll_take;
  logic              pend_hit;
  logic [LVL_W-1:0]  pend_lvl;
  logic              serv_hit;
  logic [LVL_W-1:0]  serv_lvl;
  logic              poll_hit;
  logic [LVL_W-1:0]  poll_lvl;
  logic              beats_serv;
  logic              ack_take;
  logic [NLVL-1:0]   isr_set;
  logic [NLVL-1:0]   isr_clr;

  assign pend       = irr & ~mask;
  assign eff_lowest = (mode == PM_ROTATE || mode == PM_SPECIFIC) ? lowest : '1;

  irq_prio_resolver #(.NLVL(NLVL)) u_pend (
    .vec(pend), .lowest(eff_lowest), .hit(pend_hit), .level(pend_lvl)
  );

  irq_prio_resolver #(.NLVL(NLVL)) u_serv (
    .vec(isr), .lowest(eff_lowest), .hit(serv_hit), .level(serv_lvl)
  );

  // Polling always uses the fixed order.
  irq_prio_resolver #(.NLVL(NLVL)) u_poll (
    .vec(pend), .lowest({LVL_W{1'b1}}), .hit(poll_hit), .level(poll_lvl)
  );

  assign beats_serv = !serv_hit || (prio_rank(pend_lvl, eff_lowest) < prio_rank(serv_lvl, eff_lowest));
  assign cpu_int    = (mode != PM_POLL) && pend_hit && beats_serv;
  assign ack_take   = cpu_inta && cpu_int;

  assign isr_set = ack_take  ? level_bit(pend_lvl) :
                   poll_take ? level_bit(poll_lvl) : '0;
  assign isr_clr = (eoi_pulse && serv_hit) ? level_bit(serv_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= irq_lines;
      isr <= (isr & ~isr_clr) | isr_set;
    end
  end

  irq_reg_if #(.NLVL(NLVL)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irr(irr), .isr(isr),
    .poll_hit(poll_hit), .poll_level(poll_lvl),
    .serv_hit(serv_hit), .serv_level(serv_lvl),
    .mask(mask), .mode(mode), .lowest(lowest),
    .base(base), .wide(wide),
    .eoi_pulse(eoi_pulse), .poll_take(poll_take)
  );

  irq_vector_gen #(.NLVL(NLVL), .ADDR_W(ADDR_W)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .fire(ack_take), .level(pend_lvl),
    .base(base), .wide(wide),
    .valid(vec_valid), .addr(vec_addr)
  );

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int NLVL = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_int,
  input logic              cpu_inta,
  input logic              vec_valid,
  input logic [2*NLVL-1:0] vec_addr,
  input logic [NLVL-1:0]   irr,
  input logic [NLVL-1:0]   mask,
  input logic [NLVL-1:0]   isr,
  input prio_mode_e        mode,
  input logic              eoi_pulse,
  input logic              poll_take
);

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((irr & ~mask) != '0));

  p_vec_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_inta && cpu_int) |=> vec_valid);

  p_vec_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(cpu_inta && cpu_int));

  p_ack_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_inta && cpu_int && !eoi_pulse) |=> ($countones(isr) == $countones($past(isr)) + 1));

  p_vec_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[1:0] == 2'b00));

  p_eoi_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && (isr != '0) && !(cpu_inta && cpu_int) && !poll_take)
      |=> ($countones(isr) + 1 == $countones($past(isr))));

  p_poll_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_POLL) |-> !cpu_int);

endmodule

bind irq_prio_ctrl irq_prio_chk #(.NLVL(NLVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_int(cpu_int), .cpu_inta(cpu_inta),
  .vec_valid(vec_valid), .vec_addr(vec_addr), .irr(irr), .mask(mask),
  .isr(isr), .mode(mode), .eoi_pulse(eoi_pulse), .poll_take(poll_take)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_lines = '0;
  logic        bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cpu_int;
  logic        cpu_inta = 1'b0;
  logic        vec_valid;
  logic [15:0] vec_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  int          base_val = 0, spacing = 4;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_int(cpu_int), .cpu_inta(cpu_inta),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a0, logic [7:0] d);
    @(negedge clk); bus_a0 = a0; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic a0, logic [7:0] exp, string tag);
    @(negedge clk); bus_a0 = a0; bus_rd = 1'b1;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic lines(logic [7:0] v);
    @(negedge clk); irq_lines = v;
    @(negedge clk);
  endtask

  function automatic int slot(int lvl);
    int span = spacing * 8;
    return (base_val / span) * span + lvl * spacing;
  endfunction

  // Driver: queue the expected handler address, then acknowledge.
  task automatic ack(int lvl, string tag);
    chk({tag, " int before ack"}, cpu_int, 1);
    exp_q.push_back(16'(slot(lvl)));
    tag_q.push_back(tag);
    @(negedge clk); cpu_inta = 1'b1;
    @(negedge clk); cpu_inta = 1'b0;
  endtask

  // Monitor: compare each strobe with the oldest queued address.
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected vec_valid", 1, 0);
      end else begin
        chk(tag_q.pop_front(), vec_addr, exp_q.pop_front());
      end
    end
  end

  task automatic load_base(bit w, int b);
    wr(0, 8'(w));
    wr(1, 8'(b >> 8));
    wr(1, 8'(b));
    base_val = b; spacing = w ? 8 : 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu_int", cpu_int, 0);
    chk("R1 vec_valid", vec_valid, 0);
    rd_chk(1, 8'hFF, "R1 mask reset");
    rd_chk(0, 8'h00, "R1 request reset");

    // R2 / R3 masked requests
    lines(8'h24);
    rd_chk(0, 8'h24, "R2 request readback");
    chk("R3 masked no int", cpu_int, 0);

    // R7 base load does not touch the mask
    load_base(0, 16'h1234);
    rd_chk(1, 8'hFF, "R7 mask kept through base load");
    wr(1, 8'hFB);
    rd_chk(1, 8'hFB, "R3 mask readback");
    chk("R3 unmasked level raises int", cpu_int, 1);
    wr(1, 8'h00);

    // R4 fixed order, R6/R7 vector
    ack(2, "R4 R7 fixed level2 addr");
    wr(0, 8'h81);
    rd_chk(0, 8'h04, "R12 R6 isr after ack");
    wr(0, 8'h80);
    rd_chk(0, 8'h24, "R12 request select");
    chk("R5 same level blocked", cpu_int, 0);
    lines(8'h25);
    chk("R5 higher level preempts", cpu_int, 1);
    ack(0, "R4 level0 addr");
    wr(0, 8'h81);
    rd_chk(0, 8'h05, "R6 nested isr");
    wr(0, 8'h40);
    rd_chk(0, 8'h04, "R8 eoi clears highest");
    wr(0, 8'h40);
    rd_chk(0, 8'h00, "R8 eoi clears last");
    wr(0, 8'h40);
    rd_chk(0, 8'h00, "R8 eoi on empty");

    // R7 spacing 8
    load_base(1, 16'hABFF);
    ack(0, "R7 wide level0");
    wr(0, 8'h40);
    lines(8'h80);
    ack(7, "R7 wide level7");
    wr(0, 8'h40);

    // R9 rotating
    wr(0, 8'h21);
    lines(8'h81);
    ack(0, "R9 first level0");
    wr(0, 8'h40);
    ack(7, "R9 level7 after rotation");
    wr(0, 8'h40);
    ack(0, "R9 level0 after rotation");
    wr(0, 8'h40);

    // R10 specific
    wr(0, 8'h22);
    wr(0, 8'h63);
    lines(8'h19);
    ack(4, "R10 level4 after lowest3");
    chk("R5 top level in service blocks", cpu_int, 0);
    wr(0, 8'h40);
    ack(4, "R10 order unchanged by eoi");
    wr(0, 8'h40);
    wr(1, 8'h10);
    ack(0, "R10 R3 next after masked 4");
    wr(0, 8'h40);
    wr(1, 8'h00);

    // R11 polled
    wr(0, 8'h23);
    lines(8'h30);
    chk("R11 no int when polled", cpu_int, 0);
    rd_chk(0, 8'h84, "R11 poll word");
    lines(8'h00);
    rd_chk(0, 8'h00, "R11 poll empty");
    wr(0, 8'h20);
    wr(0, 8'h81);
    rd_chk(0, 8'h10, "R11 poll read took service");
    wr(0, 8'h40);
    rd_chk(0, 8'h00, "R8 final eoi");

    repeat (3) @(negedge clk);
    chk("R6 all vectors seen", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R1 watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule